// File: doc/BRIEF.md
# Timestamped Event Trace Buffer

This block watches a group of event strobes and, each time one fires, stores a trace record. The record holds the value of a shared cycle counter taken in the cycle the strobe was high, the number of the event that fired, a data word offered with that event, and a marker that tells whether any records were thrown away just before this one. Records wait in an on-chip memory FIFO until a consumer drains them through a valid/ready port.

Each event has a one-record waiting slot. When several strobes are high in the same cycle, their records all carry that cycle's timestamp and enter the FIFO one per cycle, lowest event number first. A full FIFO, or an event that fires again before its earlier record has left its slot, costs a record. Such a loss raises a saturating lost-record count and sets the marker on the next stored record. Start, stop and clear inputs govern the counter and capture. A typical use is recording when each of several replicated compute units starts and finishes.

Top module: `etb_top`

## Requirements
- R1: After reset the drain port shows no record (rd_valid_o low), the lost-record count is 0, capture is stopped and the cycle counter holds 0.
- R2: The counter rises by one on every clock edge while capture is running and wraps at TS_W bits. A record's timestamp equals the counter value in the cycle its strobe was sampled high.
- R3: A record holds the event number (0 to NUM_EV-1) and the data slice ev_data_i[e*DATA_W +: DATA_W] of that event, both taken in the strobe cycle.
- R4: Strobes that are high together yield records with one shared timestamp. Those records enter the FIFO one per cycle in rising event-number order.
- R5: With the FIFO empty and no other event waiting, a record whose strobe was sampled at edge k becomes visible on the drain port right after edge k+1.
- R6: The front record leaves only at an edge where rd_valid_o and rd_ready_i are both high. Until then the record's fields stay unchanged.
- R7: A record is dropped when it would be written while the FIFO already holds DEPTH entries (a read in the same cycle does not make room). Each dropped record adds one to lost_cnt_o, which saturates at all ones.
- R8: After any loss, the next record written into the FIFO has rd_ovf_o = 1. Later records have it at 0 until another loss occurs.
- R9: A strobe on an event whose slot still holds a record that is not moving to the FIFO in that cycle is lost and counted as in R7. The waiting record is kept.
- R10: While stopped, the counter holds its value and strobes are ignored. Records already waiting still move into the FIFO, and stored records can still be drained.
- R11: Clear empties the FIFO and the waiting slots and zeroes the counter, the lost count and the pending marker. Whether capture is running is decided only by start and stop.
- R12: When start and stop are high in the same cycle, stop wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Begin capture and counting |
| stop_i | input | 1 | Halt capture and counting |
| clear_i | input | 1 | Empty buffer, zero counter and lost count |
| ev_strobe_i | input | NUM_EV (4) | One strobe per event |
| ev_data_i | input | NUM_EV*DATA_W (32) | Data word per event, event e at slice e |
| rd_valid_o | output | 1 | A record is offered |
| rd_ready_i | input | 1 | Consumer accepts the offered record |
| rd_ts_o | output | TS_W (16) | Timestamp of the offered record |
| rd_id_o | output | ID_W (2) | Event number of the offered record |
| rd_data_o | output | DATA_W (8) | Data word of the offered record |
| rd_ovf_o | output | 1 | Records were lost before this one |
| lost_cnt_o | output | LOST_W (8) | Saturating count of lost records |

## Verification
The hardest state to reach is a full FIFO that still has to take a record from a waiting slot, while other slots are hit again at the same time. That is the only case in which a FIFO drop and slot collisions add to the lost count in a single cycle and the overflow marker has to outlive a long drain. The bench holds ready low and fires every strobe on every cycle well past DEPTH records, then releases ready. A behavioural model with a record queue and per-event slots predicts each drop and each marked record cycle by cycle. A second phase fires all strobes continuously with ready high, so event 0 keeps winning the arbitration and the other slots keep colliding.

// File: rtl/etb_pkg.sv
package etb_pkg;

  // Index of the lowest set bit of v; found reports whether any bit is set.
  function automatic int unsigned etb_lowest(input logic [31:0] v, output logic found);
    int unsigned idx;
    idx   = 0;
    found = 1'b0;
    for (int i = 31; i >= 0; i--) begin
      if (v[i]) begin
        idx   = i;
        found = 1'b1;
      end
    end
    return idx;
  endfunction

endpackage

// File: rtl/etb_timebase.sv
module etb_timebase #(
  parameter int TS_W = 16
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            start_i,
  input  logic            stop_i,
  input  logic            clear_i,
  output logic            run_o,
  output logic [TS_W-1:0] ts_o
);

  logic            run_q, run_d;
  logic [TS_W-1:0] ts_q, ts_d;

  always_comb begin
    run_d = run_q;
    if (stop_i)       run_d = 1'b0;
    else if (start_i) run_d = 1'b1;
    ts_d = ts_q;
    if (clear_i)    ts_d = '0;
    else if (run_q) ts_d = ts_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q <= 1'b0;
      ts_q  <= '0;
    end else begin
      run_q <= run_d;
      ts_q  <= ts_d;
    end
  end

  assign run_o = run_q;
  assign ts_o  = ts_q;

endmodule

// File: rtl/etb_stage.sv
module etb_stage
  import etb_pkg::*;
#(
  parameter int NUM_EV = 4,
  parameter int DATA_W = 8,
  parameter int TS_W   = 16,
  localparam int ID_W  = (NUM_EV > 1) ? $clog2(NUM_EV) : 1,
  localparam int CNT_W = $clog2(NUM_EV + 1)
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     clear_i,
  input  logic                     run_i,
  input  logic [TS_W-1:0]          ts_i,
  input  logic [NUM_EV-1:0]        strobe_i,
  input  logic [NUM_EV*DATA_W-1:0] data_i,
  output logic                     sel_valid_o,
  output logic [ID_W-1:0]          sel_id_o,
  output logic [TS_W-1:0]          sel_ts_o,
  output logic [DATA_W-1:0]        sel_data_o,
  output logic [CNT_W-1:0]         coll_cnt_o
);

  logic [NUM_EV-1:0] pend_q, pend_d;
  logic [NUM_EV-1:0] take, cap, coll;
  logic [TS_W-1:0]   pts_q  [NUM_EV];
  logic [DATA_W-1:0] pdat_q [NUM_EV];
  logic [31:0]       pend_ext;
  logic              any_pend;
  int unsigned       sel_idx;

  always_comb begin
    pend_ext = '0;
    pend_ext[NUM_EV-1:0] = pend_q;
    sel_idx = etb_lowest(pend_ext, any_pend);
  end

  assign sel_valid_o = any_pend;
  assign sel_id_o    = ID_W'(sel_idx);
  assign sel_ts_o    = pts_q[sel_idx[ID_W-1:0]];
  assign sel_data_o  = pdat_q[sel_idx[ID_W-1:0]];

  for (genvar e = 0; e < NUM_EV; e++) begin : g_slot
    assign take[e] = any_pend && (sel_idx == e);
    assign cap[e]  = run_i && strobe_i[e];
    assign coll[e] = cap[e] && pend_q[e] && !take[e] && !clear_i;

    always_comb begin
      pend_d[e] = pend_q[e];
      if (clear_i)      pend_d[e] = 1'b0;
      else if (cap[e])  pend_d[e] = 1'b1;
      else if (take[e]) pend_d[e] = 1'b0;
    end

    always_ff @(posedge clk) begin
      if (cap[e] && !coll[e]) begin
        pts_q[e]  <= ts_i;
        pdat_q[e] <= data_i[e*DATA_W +: DATA_W];
      end
    end
  end

  always_comb begin
    coll_cnt_o = '0;
    for (int e = 0; e < NUM_EV; e++) coll_cnt_o = coll_cnt_o + CNT_W'(coll[e]);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pend_q <= '0;
    else        pend_q <= pend_d;
  end

endmodule

// File: rtl/etb_fifo.sv
module etb_fifo #(
  parameter int W     = 27,
  parameter int DEPTH = 16,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clear_i,
  input  logic         wr_en_i,
  input  logic [W-1:0] wr_data_i,
  input  logic         rd_en_i,
  output logic [W-1:0] rd_data_o,
  output logic         full_o,
  output logic         empty_o
);

  logic [W-1:0] mem [DEPTH];
  logic [AW:0]  wp_q, wp_d, rp_q, rp_d;
  logic         do_wr, do_rd;

  assign full_o    = (wp_q[AW] != rp_q[AW]) && (wp_q[AW-1:0] == rp_q[AW-1:0]);
  assign empty_o   = (wp_q == rp_q);
  assign do_wr     = wr_en_i && !full_o;
  assign do_rd     = rd_en_i && !empty_o;
  assign rd_data_o = mem[rp_q[AW-1:0]];

  always_comb begin
    wp_d = wp_q;
    rp_d = rp_q;
    if (clear_i) begin
      wp_d = '0;
      rp_d = '0;
    end else begin
      if (do_wr) wp_d = wp_q + 1'b1;
      if (do_rd) rp_d = rp_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp_q <= '0;
      rp_q <= '0;
    end else begin
      wp_q <= wp_d;
      rp_q <= rp_d;
    end
  end

  always_ff @(posedge clk) begin
    if (do_wr && !clear_i) mem[wp_q[AW-1:0]] <= wr_data_i;
  end

endmodule

// File: rtl/etb_top.sv
module etb_top #(
  parameter int NUM_EV = 4,
  parameter int DATA_W = 8,
  parameter int TS_W   = 16,
  parameter int DEPTH  = 16,
  parameter int LOST_W = 8,
  localparam int ID_W  = (NUM_EV > 1) ? $clog2(NUM_EV) : 1,
  localparam int CNT_W = $clog2(NUM_EV + 1),
  localparam int REC_W = 1 + ID_W + TS_W + DATA_W
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     start_i,
  input  logic                     stop_i,
  input  logic                     clear_i,
  input  logic [NUM_EV-1:0]        ev_strobe_i,
  input  logic [NUM_EV*DATA_W-1:0] ev_data_i,
  output logic                     rd_valid_o,
  input  logic                     rd_ready_i,
  output logic [TS_W-1:0]          rd_ts_o,
  output logic [ID_W-1:0]          rd_id_o,
  output logic [DATA_W-1:0]        rd_data_o,
  output logic                     rd_ovf_o,
  output logic [LOST_W-1:0]        lost_cnt_o
);

  logic              run_w;
  logic [TS_W-1:0]   ts_w;
  logic              sel_valid;
  logic [ID_W-1:0]   sel_id;
  logic [TS_W-1:0]   sel_ts;
  logic [DATA_W-1:0] sel_data;
  logic [CNT_W-1:0]  coll_cnt;
  logic              fifo_full, fifo_empty, drop, wrote;
  logic [REC_W-1:0]  wr_rec, rd_rec;
  logic              ovf_q, ovf_d;
  logic [LOST_W-1:0] lost_q, lost_d;
  logic [LOST_W:0]   lost_sum;
  logic [CNT_W:0]    losses;

  etb_timebase #(.TS_W(TS_W)) u_time (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .stop_i(stop_i),
    .clear_i(clear_i), .run_o(run_w), .ts_o(ts_w)
  );

  etb_stage #(.NUM_EV(NUM_EV), .DATA_W(DATA_W), .TS_W(TS_W)) u_stage (
    .clk(clk), .rst_n(rst_n), .clear_i(clear_i), .run_i(run_w), .ts_i(ts_w),
    .strobe_i(ev_strobe_i), .data_i(ev_data_i), .sel_valid_o(sel_valid),
    .sel_id_o(sel_id), .sel_ts_o(sel_ts), .sel_data_o(sel_data),
    .coll_cnt_o(coll_cnt)
  );

  assign wrote  = sel_valid && !fifo_full && !clear_i;
  assign drop   = sel_valid && fifo_full && !clear_i;
  assign wr_rec = {ovf_q, sel_id, sel_ts, sel_data};

  etb_fifo #(.W(REC_W), .DEPTH(DEPTH)) u_fifo (
    .clk(clk), .rst_n(rst_n), .clear_i(clear_i), .wr_en_i(sel_valid),
    .wr_data_i(wr_rec), .rd_en_i(rd_ready_i), .rd_data_o(rd_rec),
    .full_o(fifo_full), .empty_o(fifo_empty)
  );

  always_comb begin
    losses   = (CNT_W+1)'(coll_cnt) + (CNT_W+1)'(drop);
    lost_sum = {1'b0, lost_q} + (LOST_W+1)'(losses);
    lost_d   = lost_sum[LOST_W] ? {LOST_W{1'b1}} : lost_sum[LOST_W-1:0];
    ovf_d    = ovf_q;
    if (losses != '0) ovf_d = 1'b1;
    else if (wrote)   ovf_d = 1'b0;
    if (clear_i) begin
      lost_d = '0;
      ovf_d  = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lost_q <= '0;
      ovf_q  <= 1'b0;
    end else begin
      lost_q <= lost_d;
      ovf_q  <= ovf_d;
    end
  end

  assign rd_valid_o = !fifo_empty;
  assign {rd_ovf_o, rd_id_o, rd_ts_o, rd_data_o} = rd_rec;
  assign lost_cnt_o = lost_q;

endmodule

// File: rtl/etb_checker.sv
module etb_checker #(
  parameter int NUM_EV = 4,
  parameter int DATA_W = 8,
  parameter int TS_W   = 16,
  parameter int LOST_W = 8,
  localparam int ID_W  = (NUM_EV > 1) ? $clog2(NUM_EV) : 1
) (
  input logic              clk,
  input logic              rst_n,
  input logic              start_i,
  input logic              stop_i,
  input logic              clear_i,
  input logic              rd_valid_o,
  input logic              rd_ready_i,
  input logic [TS_W-1:0]   rd_ts_o,
  input logic [ID_W-1:0]   rd_id_o,
  input logic [DATA_W-1:0] rd_data_o,
  input logic              rd_ovf_o,
  input logic [LOST_W-1:0] lost_cnt_o,
  input logic              run_w,
  input logic [TS_W-1:0]   ts_w
);

  p_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid_o && !rd_ready_i && !clear_i |=> rd_valid_o && $stable(rd_ts_o)
      && $stable(rd_id_o) && $stable(rd_data_o) && $stable(rd_ovf_o));

  p_lost_mono_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !clear_i |=> lost_cnt_o >= $past(lost_cnt_o));

  p_clear_r11: assert property (@(posedge clk) disable iff (!rst_n)
    clear_i |=> !rd_valid_o && lost_cnt_o == '0 && ts_w == '0);

  p_count_r2: assert property (@(posedge clk) disable iff (!rst_n)
    run_w && !clear_i |=> ts_w == $past(ts_w) + 1'b1);

  p_freeze_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !run_w && !clear_i |=> $stable(ts_w));

  p_stop_wins_r12: assert property (@(posedge clk) disable iff (!rst_n)
    start_i && stop_i |=> !run_w);

endmodule

bind etb_top etb_checker #(.NUM_EV(NUM_EV), .DATA_W(DATA_W), .TS_W(TS_W), .LOST_W(LOST_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .start_i(start_i), .stop_i(stop_i), .clear_i(clear_i),
  .rd_valid_o(rd_valid_o), .rd_ready_i(rd_ready_i), .rd_ts_o(rd_ts_o),
  .rd_id_o(rd_id_o), .rd_data_o(rd_data_o), .rd_ovf_o(rd_ovf_o),
  .lost_cnt_o(lost_cnt_o), .run_w(run_w), .ts_w(ts_w)
);

// File: tb/etb_top_bench.sv
module etb_top_bench;

  localparam int NUM_EV = 4;
  localparam int DATA_W = 8;
  localparam int TS_W   = 16;
  localparam int DEPTH  = 16;
  localparam int LOST_W = 8;
  localparam int ID_W   = 2;

  logic                     clk;
  logic                     rst_n;
  logic                     start_i, stop_i, clear_i;
  logic [NUM_EV-1:0]        ev_strobe_i;
  logic [NUM_EV*DATA_W-1:0] ev_data_i;
  logic                     rd_valid_o, rd_ready_i;
  logic [TS_W-1:0]          rd_ts_o;
  logic [ID_W-1:0]          rd_id_o;
  logic [DATA_W-1:0]        rd_data_o;
  logic                     rd_ovf_o;
  logic [LOST_W-1:0]        lost_cnt_o;

  etb_top #(.NUM_EV(NUM_EV), .DATA_W(DATA_W), .TS_W(TS_W), .DEPTH(DEPTH), .LOST_W(LOST_W)) u_etb_top (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .stop_i(stop_i), .clear_i(clear_i),
    .ev_strobe_i(ev_strobe_i), .ev_data_i(ev_data_i), .rd_valid_o(rd_valid_o),
    .rd_ready_i(rd_ready_i), .rd_ts_o(rd_ts_o), .rd_id_o(rd_id_o),
    .rd_data_o(rd_data_o), .rd_ovf_o(rd_ovf_o), .lost_cnt_o(lost_cnt_o)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  typedef struct {
    bit          ovf;
    int          id;
    logic [15:0] ts;
    logic [7:0]  data;
  } rec_t;

  rec_t        q[$];
  bit          m_run;
  logic [15:0] m_ts;
  bit          m_pend [NUM_EV];
  logic [15:0] m_pts  [NUM_EV];
  logic [7:0]  m_pdat [NUM_EV];
  int          m_lost;
  bit          m_oflag;

  int    n_chk, n_bad;
  bit    done;
  string phase;
  logic [15:0] lfsr;

  task automatic chk(input string fld, input longint act, input longint exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0d expected %0d at %0t", phase, fld, act, exp, $time);
    end
  endtask

  task automatic model_reset();
    q.delete();
    m_run = 0; m_ts = 0; m_lost = 0; m_oflag = 0;
    for (int e = 0; e < NUM_EV; e++) m_pend[e] = 0;
  endtask

  task automatic model_step();
    int  fire, loss, osz;
    bit  wrote;
    bit  pold [NUM_EV];
    rec_t r;
    fire = -1; loss = 0; wrote = 0; osz = q.size();
    for (int e = NUM_EV - 1; e >= 0; e--) if (m_pend[e]) fire = e;
    for (int e = 0; e < NUM_EV; e++) pold[e] = m_pend[e];
    if (clear_i) begin
      q.delete();
      for (int e = 0; e < NUM_EV; e++) m_pend[e] = 0;
      m_lost = 0; m_oflag = 0; m_ts = 0;
    end else begin
      if (osz > 0 && rd_ready_i) void'(q.pop_front());
      if (fire >= 0) begin
        if (osz < DEPTH) begin
          r.ovf = m_oflag; r.id = fire; r.ts = m_pts[fire]; r.data = m_pdat[fire];
          q.push_back(r);
          wrote = 1;
        end else loss++;
        m_pend[fire] = 0;
      end
      if (m_run) begin
        for (int e = 0; e < NUM_EV; e++) begin
          if (ev_strobe_i[e]) begin
            if (pold[e] && fire != e) loss++;
            else begin
              m_pend[e] = 1; m_pts[e] = m_ts; m_pdat[e] = ev_data_i[e*DATA_W +: DATA_W];
            end
          end
        end
      end
      if (loss > 0)   m_oflag = 1;
      else if (wrote) m_oflag = 0;
      m_lost = (m_lost + loss > 255) ? 255 : m_lost + loss;
      if (m_run) m_ts = m_ts + 16'd1;
    end
    if (stop_i)       m_run = 0;
    else if (start_i) m_run = 1;
  endtask

  task automatic compare();
    chk("valid", rd_valid_o, q.size() > 0);
    chk("lost", lost_cnt_o, m_lost);
    if (q.size() > 0 && rd_valid_o) begin
      chk("ts", rd_ts_o, q[0].ts);
      chk("id", rd_id_o, q[0].id);
      chk("data", rd_data_o, q[0].data);
      chk("ovf", rd_ovf_o, q[0].ovf);
    end
  endtask

  // One clock: drive at the falling edge, model at the rising edge, compare at the next falling edge.
  task automatic cyc(input logic [3:0] stb, input bit rdy, input bit st, input bit sp, input bit cl);
    lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    ev_strobe_i = stb; rd_ready_i = rdy; start_i = st; stop_i = sp; clear_i = cl;
    ev_data_i = {lfsr, lfsr ^ 16'h5a3c};
    @(posedge clk);
    if (rst_n) model_step();
    @(negedge clk);
    compare();
  endtask

  initial begin
    #(20 * 20000);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    n_chk = 0; n_bad = 0; done = 0; lfsr = 16'hace1;
    rst_n = 0; start_i = 0; stop_i = 0; clear_i = 0; ev_strobe_i = 0; ev_data_i = 0; rd_ready_i = 0;
    model_reset();
    phase = "R1";
    repeat (3) @(negedge clk);
    compare();
    rst_n = 1;
    for (int i = 0; i < 4; i++) cyc(4'hf, 1, 0, 0, 0);   // strobes ignored before start

    phase = "R2";   // single events, also R3 and R5 latency
    cyc(0, 1, 1, 0, 0);
    for (int i = 0; i < 30; i++) cyc((i % 3 == 0) ? 4'(1 << (i % 4)) : 4'h0, 1, 0, 0, 0);

    phase = "R4";
    for (int i = 0; i < 12; i++) cyc((i % 5 == 0) ? 4'hf : 4'h0, 1, 0, 0, 0);

    phase = "R6";
    for (int i = 0; i < 80; i++) cyc(lfsr[3:0] & {4{lfsr[9]}}, lfsr[7], 0, 0, 0);

    phase = "R7";   // fill and overflow with ready low
    for (int i = 0; i < 60; i++) cyc(4'hf, 0, 0, 0, 0);
    phase = "R8";
    for (int i = 0; i < 30; i++) cyc(0, 1, 0, 0, 0);
    cyc(4'h4, 1, 0, 0, 0);
    for (int i = 0; i < 6; i++) cyc(0, 1, 0, 0, 0);

    phase = "R9";
    for (int i = 0; i < 20; i++) cyc(4'hf, 1, 0, 0, 0);
    for (int i = 0; i < 10; i++) cyc(0, 1, 0, 0, 0);

    phase = "R10";
    cyc(4'h3, 0, 0, 1, 0);
    for (int i = 0; i < 10; i++) cyc(4'hf, 0, 0, 0, 0);
    for (int i = 0; i < 10; i++) cyc(4'hf, i[0], 0, 0, 0);
    cyc(0, 1, 1, 0, 0);
    for (int i = 0; i < 8; i++) cyc(4'h2, 1, 0, 0, 0);

    phase = "R11";
    for (int i = 0; i < 25; i++) cyc(4'hf, 0, 0, 0, 0);
    cyc(4'hf, 1, 0, 0, 1);
    for (int i = 0; i < 15; i++) cyc(lfsr[3:0], lfsr[2], 0, 0, 0);

    phase = "R12";
    cyc(0, 1, 1, 1, 0);
    for (int i = 0; i < 5; i++) cyc(4'h1, 1, 0, 0, 0);
    cyc(0, 1, 1, 0, 0);
    for (int i = 0; i < 200; i++) cyc(lfsr[3:0] & {4{lfsr[11]}}, lfsr[5] | lfsr[6], 0, 0, lfsr[15:10] == 6'h2a);

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

endmodule